// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable whole number N = P×B + A. It behaves like a dual-modulus prescaler (moduli P and P+1) driven by a swallow counter A and a main counter B. The prescaler modulus P is 2**PRESCALE_LOG2, which is 64 by default. In each output period the prescaler first runs A cycles at modulus P+1 and then B−A cycles at modulus P. One output period therefore lasts A(P+1) + (B−A)P = P×B + A input clocks.

The ratio comes from a packed 22-bit programming word. The word is presented together with a one-cycle load strobe. A word applies only when its register-select field matches this divider's address.

A legal word that arrives while the divider runs is held until the current period ends, so no period is ever cut short. A word that breaks the counter limits is refused: an error flag goes up and the divider keeps its old ratio. The output is a one-clock pulse at the end of every period.

Top module: `swallow_divider`

## Requirements
- R1: While running, the rising edges of `div_pulse` are spaced exactly P×B + A input clocks apart, with P = 2**PRESCALE_LOG2 (64 by default).
- R2: The fields of `prog_word` (bit 0 = LSB) are:
  - mode field: bits [21:20]
  - B: bits [19:9], MSB at bit 19
  - A: bits [8:2], MSB at bit 8
  - register select: bits [1:0]
- R3: Reset clears `div_pulse` and `cfg_err` to 0. After reset, no pulse occurs until the first legal word is accepted. The first pulse is then high in the clock that starts N rising edges after the edge that sampled the load.
- R4: `div_pulse` is high for exactly one input clock per period.
- R5: A word whose select field differs from DIV_ADDR (default 0) is ignored. It changes neither the ratio nor `cfg_err`.
- R6: A legal word loaded while the divider runs takes effect at the next period boundary. The period in progress completes at its old length.
- R7: A selected word with B < 3, A ≥ P, or A ≥ B sets `cfg_err` in the clock after the load, and the previous ratio is kept.
- R8: An accepted legal word clears `cfg_err` in the clock after its load.
- R9: The mode field has no effect on the ratio.
- R10: Within a period, the B-counter value always stays above the remaining swallow count. The P+1 prescaler cycles therefore all come before the P cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe marking `prog_word` as valid |
| prog_word | input | 22 | Packed programming word (mode, B, A, select) |
| div_pulse | output | 1 | One-clock pulse at the end of every output period |
| cfg_err | output | 1 | Set by a refused selected word, cleared by an accepted one |

## Verification
The bench sweeps every legal (A, B) pair with B from 3 to 6, plus a large pair with A = P−1. This catches a prescaler that takes the P+1 modulus for one cycle too many or too few, which would shift the spacing by one clock per error.

It loads each word in mid-period and measures the very next spacing. A design that switched ratio at once would give one truncated or stretched period.

Words at the limits are sent as well: B = 2, A = P, A = B, and A = B−1 (legal). A checker that used ≤ in place of < would accept or refuse one of these wrongly, and the ratio would then change or the flag would stay low.

Foreign-select words and nonzero mode bits are mixed in too. An address decoder that missed the select field would visibly change the spacing or raise the flag.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } sd_phase_e;

  localparam int SD_B_MIN = 3;
endpackage

// File: rtl/sd_word_decode.sv
module sd_word_decode #(
  parameter int A_W      = 7,
  parameter int B_W      = 11,
  parameter int MODE_W   = 2,
  parameter int SEL_W    = 2,
  parameter int P_LOG2   = 6,
  parameter logic [SEL_W-1:0] ADDR = '0,
  localparam int WORD_W  = MODE_W + B_W + A_W + SEL_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [A_W-1:0]    a_val,
  output logic [B_W-1:0]    b_val,
  output logic [MODE_W-1:0] mode_val,
  output logic              hit,
  output logic              legal
);
  localparam int SEL_LO  = 0;
  localparam int A_LO    = SEL_LO + SEL_W;
  localparam int B_LO    = A_LO + A_W;
  localparam int MODE_LO = B_LO + B_W;

  logic [SEL_W-1:0] sel_val;
  logic             a_below_p;
  logic             b_ok;
  logic             a_below_b;

  assign sel_val  = word[A_LO-1:SEL_LO];
  assign a_val    = word[B_LO-1:A_LO];
  assign b_val    = word[MODE_LO-1:B_LO];
  assign mode_val = word[WORD_W-1:MODE_LO];

  assign hit = (sel_val == ADDR);

  generate
    if (P_LOG2 >= A_W) begin : g_a_always_fits
      assign a_below_p = 1'b1;
    end else begin : g_a_bounded
      assign a_below_p = (a_val < A_W'(2**P_LOG2));
    end
  endgenerate

  assign b_ok      = (b_val >= B_W'(sd_pkg::SD_B_MIN));
  assign a_below_b = (B_W'(a_val) < b_val);
  assign legal     = b_ok && a_below_p && a_below_b;
endmodule

// File: rtl/sd_prescaler.sv
module sd_prescaler #(
  parameter int P_LOG2 = 6,
  localparam int CW    = P_LOG2 + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic next_hi,
  output logic tc
);
  localparam logic [CW-1:0] CNT_HI = CW'(2**P_LOG2);
  localparam logic [CW-1:0] CNT_LO = CNT_HI - CW'(1);

  logic [CW-1:0] cnt_q;

  assign tc = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start || tc) begin
      cnt_q <= next_hi ? CNT_HI : CNT_LO;
    end else if (en) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/sd_swallow_ctrl.sv
module sd_swallow_ctrl #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           tc,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           next_hi,
  output logic           period_end,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt
);
  logic [A_W-1:0] a_nxt;
  logic [B_W-1:0] b_nxt;

  assign period_end = tc && (b_cnt == B_W'(1));

  always_comb begin
    a_nxt = a_cnt;
    b_nxt = b_cnt;
    if (start || period_end) begin
      a_nxt = ld_a;
      b_nxt = ld_b;
    end else if (tc) begin
      b_nxt = b_cnt - B_W'(1);
      a_nxt = (a_cnt == '0) ? '0 : a_cnt - A_W'(1);
    end
  end

  assign next_hi = (a_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else begin
      a_cnt <= a_nxt;
      b_cnt <= b_nxt;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int A_W      = 7,
  parameter int B_W      = 11,
  parameter int MODE_W   = 2,
  parameter int SEL_W    = 2,
  parameter int PRESCALE_LOG2 = 6,
  parameter logic [SEL_W-1:0] DIV_ADDR = '0,
  localparam int WORD_W  = MODE_W + B_W + A_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] prog_word,
  output logic              div_pulse,
  output logic              cfg_err
);
  import sd_pkg::*;

  logic [A_W-1:0]    dec_a;
  logic [B_W-1:0]    dec_b;
  logic [MODE_W-1:0] dec_mode;
  logic              dec_hit;
  logic              dec_legal;

  sd_phase_e         phase_q;
  logic              running;
  logic [A_W-1:0]    act_a, pend_a, ld_a;
  logic [B_W-1:0]    act_b, pend_b, ld_b;
  logic              pend_v;
  logic              accept, reject, start;
  logic              tc, next_hi, period_end;
  logic [A_W-1:0]    a_cnt_w;
  logic [B_W-1:0]    b_cnt_w;

  sd_word_decode #(
    .A_W(A_W), .B_W(B_W), .MODE_W(MODE_W), .SEL_W(SEL_W),
    .P_LOG2(PRESCALE_LOG2), .ADDR(DIV_ADDR)
  ) u_dec (
    .word(prog_word), .a_val(dec_a), .b_val(dec_b), .mode_val(dec_mode),
    .hit(dec_hit), .legal(dec_legal)
  );

  assign running = (phase_q == PH_RUN);
  assign accept  = load && dec_hit && dec_legal;
  assign reject  = load && dec_hit && !dec_legal;
  assign start   = accept && !running;

  // Reload source: a fresh word on start, else any pending word, else the live ratio.
  always_comb begin
    if (start) begin
      ld_a = dec_a;
      ld_b = dec_b;
    end else if (pend_v) begin
      ld_a = pend_a;
      ld_b = pend_b;
    end else begin
      ld_a = act_a;
      ld_b = act_b;
    end
  end

  sd_swallow_ctrl #(.A_W(A_W), .B_W(B_W)) u_swallow (
    .clk(clk), .rst(rst), .start(start), .tc(tc),
    .ld_a(ld_a), .ld_b(ld_b), .next_hi(next_hi), .period_end(period_end),
    .a_cnt(a_cnt_w), .b_cnt(b_cnt_w)
  );

  sd_prescaler #(.P_LOG2(PRESCALE_LOG2)) u_pres (
    .clk(clk), .rst(rst), .en(running), .start(start),
    .next_hi(next_hi), .tc(tc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      act_a     <= '0;
      act_b     <= '0;
      pend_a    <= '0;
      pend_b    <= '0;
      pend_v    <= 1'b0;
      cfg_err   <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= period_end;
      if (reject) begin
        cfg_err <= 1'b1;
      end else if (accept) begin
        cfg_err <= 1'b0;
      end
      if (start) begin
        phase_q <= PH_RUN;
        act_a   <= dec_a;
        act_b   <= dec_b;
      end else begin
        if (period_end && pend_v) begin
          act_a  <= pend_a;
          act_b  <= pend_b;
          pend_v <= 1'b0;
        end
        if (accept) begin
          pend_a <= dec_a;
          pend_b <= dec_b;
          pend_v <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swallow_divider_checker.sv
module swallow_divider_checker #(
  parameter int A_W    = 7,
  parameter int B_W    = 11,
  parameter int MODE_W = 2,
  parameter int SEL_W  = 2,
  parameter int PRESCALE_LOG2 = 6,
  parameter logic [SEL_W-1:0] DIV_ADDR = '0,
  localparam int WORD_W = MODE_W + B_W + A_W + SEL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [WORD_W-1:0] prog_word,
  input logic              div_pulse,
  input logic              cfg_err,
  input logic              running,
  input logic [A_W-1:0]    act_a,
  input logic [B_W-1:0]    act_b,
  input logic [A_W-1:0]    a_cnt,
  input logic [B_W-1:0]    b_cnt
);
  logic [A_W-1:0] w_a;
  logic [B_W-1:0] w_b;
  logic           w_hit, w_legal, act_legal;

  assign w_a   = prog_word[SEL_W +: A_W];
  assign w_b   = prog_word[SEL_W + A_W +: B_W];
  assign w_hit = (prog_word[SEL_W-1:0] == DIV_ADDR);
  assign w_legal = ((w_a >> PRESCALE_LOG2) == '0) && (w_b > B_W'(2)) &&
                   (w_b > B_W'(w_a));
  assign act_legal = ((act_a >> PRESCALE_LOG2) == '0) && (act_b > B_W'(2)) &&
                     (act_b > B_W'(act_a));

  assert_pulse_narrow_R4: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !running |-> !div_pulse);
  assert_bad_word_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (load && w_hit && !w_legal) |=> cfg_err);
  assert_good_word_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (load && w_hit && w_legal) |=> !cfg_err);
  assert_foreign_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (load && !w_hit) |=> $stable(cfg_err));
  assert_ratio_stays_legal_R7: assert property (@(posedge clk) disable iff (rst)
    running |-> act_legal);
  assert_swallow_first_R10: assert property (@(posedge clk) disable iff (rst)
    running |-> (b_cnt > B_W'(a_cnt)));
endmodule

bind swallow_divider swallow_divider_checker #(
  .A_W(A_W), .B_W(B_W), .MODE_W(MODE_W), .SEL_W(SEL_W),
  .PRESCALE_LOG2(PRESCALE_LOG2), .DIV_ADDR(DIV_ADDR)
) u_checker (
  .clk(clk), .rst(rst), .load(load), .prog_word(prog_word),
  .div_pulse(div_pulse), .cfg_err(cfg_err), .running(running),
  .act_a(act_a), .act_b(act_b), .a_cnt(a_cnt_w), .b_cnt(b_cnt_w)
);

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int P = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [21:0] prog_word = '0;
  logic        div_pulse, cfg_err;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int cur_n = 0;
  bit done = 0;

  swallow_divider u_swallow_divider (
    .clk(clk), .rst(rst), .load(load), .prog_word(prog_word),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [21:0] mk(input int mode, input int a, input int b,
                                     input int sel);
    logic [1:0]  m2 = mode[1:0];
    logic [10:0] b11 = b[10:0];
    logic [6:0]  a7 = a[6:0];
    logic [1:0]  s2 = sel[1:0];
    return {m2, b11, a7, s2};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives the word for one clock, returns at the next negedge.
  task automatic send(input logic [21:0] w, output int t_load);
    load = 1'b1;
    prog_word = w;
    @(negedge clk);
    load = 1'b0;
    t_load = cyc;
  endtask

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!div_pulse);
    t = cyc;
  endtask

  // Reload mid-period right after a pulse, check the old period finishes, then the new spacing.
  task automatic retune(input int mode, input int a, input int b, input int sel,
                        input bit expect_take, input string req);
    int p0, p1, p2, tl, new_n;
    new_n = expect_take ? (P * b + a) : cur_n;
    wait_pulse(p0);
    @(negedge clk);
    check("R4 pulse width", int'(div_pulse), 0);
    send(mk(mode, a, b, sel), tl);
    wait_pulse(p1);
    check("R6 old period kept", p1 - p0, cur_n);
    wait_pulse(p2);
    check(req, p2 - p1, new_n);
    cur_n = new_n;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int tl, tp, e0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset pulse", int'(div_pulse), 0);
    check("R3 reset flag", int'(cfg_err), 0);

    // Idle: no pulses without a word; foreign and illegal words do not start it.
    send(mk(0, 0, 3, 2), tl);
    check("R5 foreign flag", int'(cfg_err), 0);
    send(mk(0, 0, 2, 0), tl);
    check("R7 B=2 flag", int'(cfg_err), 1);
    begin
      int seen = 0;
      repeat (400) begin
        @(negedge clk);
        if (div_pulse) seen++;
      end
      check("R3 idle quiet", seen, 0);
    end

    // First legal load: B=3, A=0, mode field nonzero.
    send(mk(3, 0, 3, 0), tl);
    check("R8 flag cleared", int'(cfg_err), 0);
    cur_n = P * 3;
    wait_pulse(tp);
    check("R3 first pulse", tp - tl, cur_n);

    // Sweep of all legal pairs with small B (R1, R10, R2).
    for (int b = 3; b <= 6; b++) begin
      for (int a = 0; a < b; a++) begin
        retune(0, a, b, 0, 1'b1, "R1 R10 R2 spacing");
      end
    end
    retune(0, 63, 64, 0, 1'b1, "R1 A=P-1 spacing");
    retune(2, 7, 9, 0, 1'b1, "R9 mode ignored");

    // Refused words keep the ratio and raise the flag.
    retune(0, 64, 100, 0, 1'b0, "R7 A=P ratio kept");
    check("R7 A=P flag", int'(cfg_err), 1);
    retune(0, 5, 5, 0, 1'b1 ^ 1'b1, "R7 A=B ratio kept");
    check("R7 A=B flag", int'(cfg_err), 1);
    retune(1, 4, 5, 0, 1'b1, "R8 A=B-1 accepted");
    check("R8 flag cleared", int'(cfg_err), 0);
    e0 = int'(cfg_err);
    retune(0, 2, 2, 1, 1'b0, "R5 foreign ratio kept");
    check("R5 foreign flag", int'(cfg_err), e0);
    retune(0, 1, 4, 3, 1'b0, "R5 foreign legal ignored");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule